// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Gating

This block turns bytes into asynchronous serial frames on a single line output. A character leaves a transmit buffer through a valid/pop interface. The block then sends a low start bit and the data bits, least significant bit first. An optional parity bit and one or more high stop bits follow. All bit timing comes from a single-cycle enable that pulses at sixteen times the bit rate. The block counts these pulses itself, so it needs no clock of its own.

The word length, parity and stop length are read from configuration inputs when a character is taken. They stay fixed until that frame ends. A break control forces the line low at once. Frame timing keeps running behind the break, so the character under way finishes at its normal time. When clear-to-send gating is on, a new character is only taken while the clear-to-send input is active. A frame already on the line always finishes. An empty flag shows when both the buffer and the shifter have nothing left to send.

Top module: `sertx_core`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_empty` is 1 while `buf_valid` is 0, and `buf_pop` is 0.
- R2: A frame is a 0 start bit followed by the data bits sent LSB first. The number of data bits is set by `cfg_wlen`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Every start, data and parity bit lasts 16 pulses of `tick16`.
- R3: With `cfg_par_en`=1, one parity bit follows the data bits. With `cfg_par_odd`=0 the count of ones in the data bits plus the parity bit is even. With `cfg_par_odd`=1 that count is odd. With `cfg_par_en`=0 no parity bit is sent.
- R4: The stop level is 1. With `cfg_stop_long`=0 it lasts 16 pulses. With `cfg_stop_long`=1 it lasts 24 pulses for a 5-bit word and 32 pulses for 6, 7 or 8 bits.
- R5: `buf_pop` is high for one cycle, in the cycle where the transmitter is idle and a character may start. `buf_data` and the configuration are taken in that cycle, and later changes do not alter the frame in progress. The next character is taken in the cycle after the last stop pulse.
- R6: With `cfg_auto_cts`=1 and `cts_active`=0, no character is taken. A frame in progress when `cts_active` falls still finishes. With `cfg_auto_cts`=0, `cts_active` has no effect.
- R7: While `cfg_break`=1, `tx_line` is 0 in that same cycle, whether the transmitter is idle or busy. Frame timing keeps running during the break, and the frame ends at its normal time.
- R8: `tx_empty` is 1 exactly when `buf_valid` is 0 and no frame is in progress.
- R9: Frame timing moves forward only on cycles where `tick16`=1. While `tick16` stays 0, `tx_line` holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable that pulses at sixteen times the bit rate |
| cfg_wlen | input | 2 | Word length: 0 to 3 selects 5 to 8 bits |
| cfg_par_en | input | 1 | Send a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop_long | input | 1 | Long stop: 1.5 bits for a 5-bit word, 2 bits otherwise |
| cfg_break | input | 1 | Force the line low |
| cfg_auto_cts | input | 1 | Gate the start of each character on clear-to-send |
| cts_active | input | 1 | Clear-to-send, 1 means the far end may receive |
| buf_valid | input | 1 | Transmit buffer holds a character |
| buf_data | input | 8 | Character at the head of the buffer |
| buf_pop | output | 1 | Head character taken this cycle |
| tx_line | output | 1 | Serial output, idles high |
| tx_empty | output | 1 | Buffer and shifter both empty |

## Verification
Some rules hold on every cycle and are checked by assertions. The pulse counter never reaches its current limit. A start bit can only lead to the data phase. A finished stop phase returns the block to idle. A pop is always followed by a busy state. An idle transmitter stays idle while clear-to-send gating blocks it, and stays idle in the cycle after the empty flag is shown.

Other behaviours can only be shown by the bench scenarios. These are the exact level and length of every bit for each word length, parity mode and stop setting. They also include the 24-pulse stop of a 5-bit word, the frame that finishes after clear-to-send drops, a break that masks the line without shifting the frame's end, and a held line while the 16x enable pauses.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        WLEN_5 = 2'd0,
        WLEN_6 = 2'd1,
        WLEN_7 = 2'd2,
        WLEN_8 = 2'd3
    } wlen_e;

    typedef struct packed {
        wlen_e wlen;
        logic  par_en;
        logic  par_odd;
        logic  stop_long;
    } frame_cfg_t;

    // number of data bits carried by a word length code
    function automatic logic [3:0] data_bit_count(wlen_e w);
        return 4'd5 + {2'b00, w};
    endfunction

    // parity over the active data bits; odd parity inverts the even result
    function automatic logic calc_parity(logic [CHAR_W-1:0] d, wlen_e w, logic odd);
        logic [1:0]        wv;
        logic [CHAR_W-1:0] m;
        wv = w;
        m  = {CHAR_W{1'b1}} >> (2'd3 - wv);
        return (^(d & m)) ^ odd;
    endfunction

    // stop level length in 16x pulses
    function automatic int stop_tick_count(frame_cfg_t c, int tpb);
        if (!c.stop_long) return tpb;
        if (c.wlen == WLEN_5) return tpb + tpb / 2;
        return 2 * tpb;
    endfunction

endpackage

// File: rtl/sertx_timer.sv
module sertx_timer #(
    parameter int TPB = 16,
    parameter int CW  = $clog2(2 * TPB + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt;

    assign done = run && tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < limit));

    // R2
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (cnt == '0));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         lsb
);

    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (load) begin
            sh <= din;
        end else if (shift) begin
            sh <= {1'b0, sh[W-1:1]};
        end
    end

    assign lsb = sh[0];

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
#(
    parameter int TPB = 16,
    parameter int CW  = $clog2(2 * TPB + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_cfg_t        cfg_in,
    input  logic              start_ok,
    input  logic              bit_done,
    input  logic              data_lsb,
    input  logic [CHAR_W-1:0] load_data,
    output tx_state_e         state,
    output logic              load,
    output logic              shift,
    output logic              line_level,
    output logic [CW-1:0]     bit_limit
);

    frame_cfg_t cfg_q;
    logic [3:0] bit_idx;
    logic       par_q;
    logic       last_data;

    assign load      = (state == ST_IDLE) && start_ok;
    assign shift     = (state == ST_DATA) && bit_done;
    assign last_data = (bit_idx == data_bit_count(cfg_q.wlen) - 4'd1);
    assign bit_limit = (state == ST_STOP) ? CW'(stop_tick_count(cfg_q, TPB)) : CW'(TPB);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            bit_idx <= '0;
            par_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (load) begin
                        state <= ST_START;
                        cfg_q <= cfg_in;
                        par_q <= calc_parity(load_data, cfg_in.wlen, cfg_in.par_odd);
                    end
                end
                ST_START: begin
                    if (bit_done) begin
                        state   <= ST_DATA;
                        bit_idx <= '0;
                    end
                end
                ST_DATA: begin
                    if (bit_done) begin
                        if (last_data) begin
                            state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + 4'd1;
                        end
                    end
                end
                ST_PARITY: begin
                    if (bit_done) state <= ST_STOP;
                end
                ST_STOP: begin
                    if (bit_done) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_START:  line_level = 1'b0;
            ST_DATA:   line_level = data_lsb;
            ST_PARITY: line_level = par_q;
            default:   line_level = 1'b1;
        endcase
    end

    // R2
    start_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START) |=> (state == ST_START || state == ST_DATA));

    // R4
    stop_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP && bit_done) |=> (state == ST_IDLE));

    // R3
    par_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && !cfg_q.par_en) |=> (state != ST_PARITY));

endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop_long,
    input  logic              cfg_break,
    input  logic              cfg_auto_cts,
    input  logic              cts_active,
    input  logic              buf_valid,
    input  logic [CHAR_W-1:0] buf_data,
    output logic              buf_pop,
    output logic              tx_line,
    output logic              tx_empty
);

    localparam int CW = $clog2(2 * TICKS_PER_BIT + 1);

    frame_cfg_t    cfg;
    tx_state_e     state;
    logic          start_ok;
    logic          bit_done;
    logic          data_lsb;
    logic          do_load;
    logic          do_shift;
    logic          line_level;
    logic [CW-1:0] bit_limit;

    assign cfg.wlen      = wlen_e'(cfg_wlen);
    assign cfg.par_en    = cfg_par_en;
    assign cfg.par_odd   = cfg_par_odd;
    assign cfg.stop_long = cfg_stop_long;

    assign start_ok = buf_valid && (!cfg_auto_cts || cts_active);

    sertx_ctrl #(.TPB(TICKS_PER_BIT), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cfg_in     (cfg),
        .start_ok   (start_ok),
        .bit_done   (bit_done),
        .data_lsb   (data_lsb),
        .load_data  (buf_data),
        .state      (state),
        .load       (do_load),
        .shift      (do_shift),
        .line_level (line_level),
        .bit_limit  (bit_limit)
    );

    sertx_timer #(.TPB(TICKS_PER_BIT), .CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (state != ST_IDLE),
        .tick  (tick16),
        .limit (bit_limit),
        .done  (bit_done)
    );

    sertx_shifter #(.W(CHAR_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (do_load),
        .shift (do_shift),
        .din   (buf_data),
        .lsb   (data_lsb)
    );

    assign buf_pop  = do_load;
    assign tx_line  = cfg_break ? 1'b0 : line_level;
    assign tx_empty = !buf_valid && (state == ST_IDLE);

    // R5
    pop_busy_chk: assert property (@(posedge clk) disable iff (rst)
        buf_pop |=> (state != ST_IDLE));

    // R6
    cts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && cfg_auto_cts && !cts_active) |=> (state == ST_IDLE));

    // R8
    empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tx_empty |=> (state == ST_IDLE));

endmodule

// File: tb/test_sertx_core.sv
module test_sertx_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop_long = 1'b0;
    logic       cfg_break = 1'b0;
    logic       cfg_auto_cts = 1'b0;
    logic       cts_active = 1'b1;
    logic       buf_valid = 1'b0;
    logic [7:0] buf_data = 8'h00;
    logic       buf_pop;
    logic       tx_line;
    logic       tx_empty;

    sertx_core i_sertx_core (
        .clk(clk), .rst(rst), .tick16(tick16),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop_long(cfg_stop_long), .cfg_break(cfg_break),
        .cfg_auto_cts(cfg_auto_cts), .cts_active(cts_active),
        .buf_valid(buf_valid), .buf_data(buf_data), .buf_pop(buf_pop),
        .tx_line(tx_line), .tx_empty(tx_empty)
    );

    always #4 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    byte unsigned byte_q[$];
    int  m_lv[$];
    int  m_dur[$];
    int  m_left = 0;
    bit  m_busy = 1'b0;
    bit  took = 1'b0;
    int  tick_div = 3;
    int  tick_cnt = 0;
    bit  tick_hold = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // build the expected frame as level/duration pairs
    task automatic build_frame(input byte unsigned d);
        int nb;
        int p;
        nb = 5 + int'(cfg_wlen);
        m_lv.push_back(0); m_dur.push_back(16);
        p = 0;
        for (int i = 0; i < nb; i++) begin
            m_lv.push_back(int'(d[i])); m_dur.push_back(16);
            p = p ^ int'(d[i]);
        end
        if (cfg_par_en) begin
            m_lv.push_back(p ^ int'(cfg_par_odd)); m_dur.push_back(16);
        end
        m_lv.push_back(1);
        if (!cfg_stop_long) m_dur.push_back(16);
        else if (nb == 5)   m_dur.push_back(24);
        else                m_dur.push_back(32);
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0; m_lv.delete(); m_dur.delete(); m_left = 0; took = 1'b0;
        end else if (!m_busy) begin
            if (buf_valid && (!cfg_auto_cts || cts_active)) begin
                build_frame(buf_data);
                m_busy = 1'b1; m_left = m_dur[0]; took = 1'b1;
            end
        end else if (tick16) begin
            m_left--;
            if (m_left == 0) begin
                void'(m_lv.pop_front());
                void'(m_dur.pop_front());
                if (m_lv.size() == 0) m_busy = 1'b0;
                else m_left = m_dur[0];
            end
        end
    end

    // per-cycle comparison, away from the edges
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            chk({cur_req, " line"}, int'(tx_line),
                cfg_break ? 0 : (m_busy ? m_lv[0] : 1));
            chk({cur_req, " pop R5"}, int'(buf_pop),
                int'(!m_busy && buf_valid && (!cfg_auto_cts || cts_active)));
            chk({cur_req, " empty R8"}, int'(tx_empty), int'(!m_busy && !buf_valid));
        end
    end

    // buffer and 16x enable drivers
    always @(negedge clk) begin
        if (took) begin
            void'(byte_q.pop_front());
            took = 1'b0;
        end
        buf_valid = (byte_q.size() > 0);
        buf_data  = (byte_q.size() > 0) ? byte_q[0] : 8'h00;
        if (tick_hold) begin
            tick16 = 1'b0;
        end else begin
            tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
            tick16 = (tick_cnt == 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic push(input byte unsigned b);
        @(negedge clk);
        byte_q.push_back(b);
    endtask

    task automatic set_cfg(input int wl, input bit pe, input bit po, input bit sl);
        @(negedge clk);
        cfg_wlen = wl[1:0]; cfg_par_en = pe; cfg_par_odd = po; cfg_stop_long = sl;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while ((m_busy || byte_q.size() > 0 || buf_valid) && n < 20000);
        repeat (3) @(posedge clk);
    endtask

    task automatic sample();
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        sample();
        // R1 reset state
        chk("R1 idle line", int'(tx_line), 1);
        chk("R1 empty", int'(tx_empty), 1);
        chk("R1 no pop", int'(buf_pop), 0);

        // R2 word lengths, 1 stop, no parity
        cur_req = "R2";
        set_cfg(3, 0, 0, 0); push(8'h55); push(8'hA3); wait_done();
        set_cfg(0, 0, 0, 0); push(8'h1B); wait_done();
        set_cfg(1, 0, 0, 0); push(8'h2E); wait_done();
        set_cfg(2, 0, 0, 0); push(8'h71); wait_done();
        chk("R2 idle after frames", int'(tx_line), 1);

        // R3 parity
        cur_req = "R3";
        set_cfg(3, 1, 0, 0); push(8'hB7); push(8'h00); wait_done();
        set_cfg(3, 1, 1, 0); push(8'hB7); push(8'h00); wait_done();
        set_cfg(0, 1, 1, 0); push(8'hE5); wait_done();
        chk("R3 idle after parity frames", int'(tx_empty), 1);

        // R4 stop lengths
        cur_req = "R4";
        set_cfg(0, 0, 0, 1); push(8'h0A); push(8'h15); wait_done();
        set_cfg(3, 1, 0, 1); push(8'hC3); wait_done();
        set_cfg(2, 0, 0, 1); push(8'h3D); wait_done();
        chk("R4 idle after long stops", int'(tx_line), 1);

        // R5 config latched at take, back-to-back queue
        cur_req = "R5";
        set_cfg(3, 1, 1, 0); push(8'h96); push(8'h4F); push(8'hF0);
        repeat (120) @(posedge clk);
        set_cfg(0, 0, 0, 1);
        wait_done();
        chk("R5 queue drained", byte_q.size(), 0);

        // R6 clear-to-send gating
        cur_req = "R6";
        set_cfg(3, 0, 0, 0);
        @(negedge clk); cfg_auto_cts = 1'b1; cts_active = 1'b0;
        push(8'h3C);
        repeat (100) @(posedge clk);
        sample();
        chk("R6 held line", int'(tx_line), 1);
        chk("R6 held not empty", int'(tx_empty), 0);
        chk("R6 held no pop", int'(buf_pop), 0);
        @(negedge clk); cts_active = 1'b1;
        push(8'h81);
        repeat (300) @(posedge clk);
        @(negedge clk); cts_active = 1'b0;
        repeat (700) @(posedge clk);
        sample();
        chk("R6 frame finished, line", int'(tx_line), 1);
        chk("R6 next char held", byte_q.size(), 1);
        @(negedge clk); cts_active = 1'b1;
        wait_done();
        @(negedge clk); cfg_auto_cts = 1'b0; cts_active = 1'b0;
        push(8'h5A); wait_done();
        chk("R6 gating off sends", byte_q.size(), 0);
        @(negedge clk); cts_active = 1'b1;

        // R7 break
        cur_req = "R7";
        push(8'hFF);
        repeat (200) @(posedge clk);
        @(negedge clk); cfg_break = 1'b1;
        repeat (100) @(posedge clk);
        sample();
        chk("R7 break mid frame", int'(tx_line), 0);
        @(negedge clk); cfg_break = 1'b0;
        wait_done();
        @(negedge clk); cfg_break = 1'b1;
        sample();
        chk("R7 break idle line", int'(tx_line), 0);
        chk("R7 break idle empty", int'(tx_empty), 1);
        @(negedge clk); cfg_break = 1'b0;

        // R9 pulse-driven timing
        cur_req = "R9";
        @(negedge clk); tick_div = 1;
        push(8'h6B); push(8'h94); wait_done();
        @(negedge clk); tick_div = 2;
        push(8'h0F);
        repeat (60) @(posedge clk);
        @(negedge clk); tick_hold = 1'b1;
        sample();
        begin
            int lv0;
            lv0 = int'(tx_line);
            repeat (80) @(posedge clk);
            sample();
            chk("R9 line held without pulses", int'(tx_line), lv0);
        end
        @(negedge clk); tick_hold = 1'b0;
        wait_done();
        chk("R9 final idle", int'(tx_line), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule